// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Page Buffer

This block is a byte-addressed memory that answers as a slave on a two-wire serial bus with a clock line and an open-drain data line. A system clock that runs at least ten times faster than the bus clock samples both lines. The block detects START and STOP conditions, decodes a control byte and a word address, and then serves reads or accepts writes. The memory is a register file that comes out of reset erased to 0xFF. Its size is a parameter: 512 bytes with a 16-byte page, or 128 bytes with an 8-byte page.

Written data first goes into a page buffer. The array takes the buffered bytes only when a STOP arrives. That STOP starts a timed internal write cycle. For the whole cycle the slave acknowledges nothing, so a master can find the end of the cycle by polling with a write control byte. A write-protect input blocks every commit and leaves reads working. A parameter chooses its polarity: active-high protect, or active-low write enable.

The block has no streaming data interface. All pins are plain: the two bus lines, the data-line pull-down enable, and the protect input.

Top module: `twe_eeprom`

## Requirements
- R1: START is the data line falling while the clock line is high, and STOP is the data line rising while the clock line is high. The slave changes its pull-down only while the synchronised clock line is low.
- R2: The slave acknowledges the first byte after START only if its upper four bits are 1010. For any other value it leaves the line released for that byte and for every byte up to the next START.
- R3: In the control byte, bit 0 is R/W (1 = read). Bits 3 and 2 are ignored. Bit 1 becomes word-address bit 8 in the 512-byte configuration and is ignored in the 128-byte configuration.
- R4: A byte write is control byte, word address, one data byte, STOP. The word address loads the address pointer. The data byte reaches the array at STOP.
- R5: The pointer's in-page bits step once per received data byte and wrap inside the page. The bits above the page stay fixed, so a byte past the page size overwrites an earlier byte of the same page.
- R6: A commit starts an internal cycle of WR_CYCLES system clocks. During that cycle every control byte, including a write control byte used for polling, gets no acknowledge.
- R7: A read returns the byte at the pointer and then advances the pointer. A read with no address phase therefore returns the last accessed address plus one. A dummy write of the address followed by a repeated START gives a random read.
- R8: While the master acknowledges, the slave keeps sending the next byte, with the pointer wrapping from the last address to 0. After a master no-acknowledge, the slave leaves the data line released.
- R9: While the protect input is active at STOP, the slave still acknowledges the address and data bytes, writes nothing and starts no internal cycle. With WP_ACTIVE_HIGH = 1, wp_i high protects. With WP_ACTIVE_HIGH = 0, wp_i low protects.
- R10: After reset every byte reads 0xFF, the pointer is 0 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire (wired-AND) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| wp_i | input | 1 | Write-protect input, polarity set by WP_ACTIVE_HIGH |

## Verification
The checker assumes the bus master changes the data line only while the clock line is low, except when it forms START and STOP. It also assumes each bus level lasts well over three system clocks, and that the protect input stays steady around each STOP. From these it concludes that the slave raises its pull-down only in a low phase, never pulls the line during the internal cycle or while the master acknowledges, and starts a cycle only when protection was off at STOP. The bench master moves the data line six system clocks after each clock-line fall and holds every bus phase for six clocks. It changes wp_i only while the bus is idle. Random transfers choose addresses, lengths up to twelve bytes, payloads and the ignored control bits within these rules.

// File: rtl/twe_pkg.sv
package twe_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CTRL, ST_CACK, ST_ADDR, ST_AACK,
    ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } twe_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/twe_sync.sv
module twe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_sh, sda_sh;

  // lines idle high; reset to high so no false condition after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[DEPTH-2:0], scl_i};
      sda_sh <= {sda_sh[DEPTH-2:0], sda_i};
    end
  end

  logic scl_prev, sda_prev;
  assign scl_q    = scl_sh[STAGES-1];
  assign sda_q    = sda_sh[STAGES-1];
  assign scl_prev = scl_sh[STAGES];
  assign sda_prev = sda_sh[STAGES];

  assign scl_rise  = scl_q & ~scl_prev;
  assign scl_fall  = ~scl_q & scl_prev;
  assign start_det = scl_q & scl_prev & sda_prev & ~sda_q;
  assign stop_det  = scl_q & scl_prev & ~sda_prev & sda_q;
endmodule

// File: rtl/twe_store.sv
module twe_store #(
  parameter int AW        = 9,
  parameter int PW        = 4,
  parameter int WR_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          buf_clr,
  input  logic          buf_we,
  input  logic [PW-1:0] buf_idx,
  input  logic [7:0]    buf_din,
  input  logic          commit,
  input  logic [AW-PW-1:0] page_hi,
  output logic          busy
);
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PW;
  localparam int CW    = $clog2(WR_CYCLES + 1);

  logic [7:0]      mem  [DEPTH];
  logic [7:0]      pbuf [PAGE];
  logic [PAGE-1:0] pval;
  logic [CW-1:0]   tmr;

  // array: whole page lands in one clock at commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++)
        if (pval[i]) mem[{page_hi, PW'(i)}] <= pbuf[i];
    end
  end

  // page buffer with a per-slot valid mask
  generate
    for (genvar g = 0; g < PAGE; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pbuf[g] <= 8'h00;
          pval[g] <= 1'b0;
        end else if (buf_we && buf_idx == PW'(g)) begin
          pbuf[g] <= buf_din;
          pval[g] <= 1'b1;
        end else if (buf_clr) begin
          pval[g] <= 1'b0;
        end
      end
    end
  endgenerate

  // self-timed write cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tmr <= '0;
    else if (commit)     tmr <= CW'(WR_CYCLES);
    else if (tmr != '0)  tmr <= tmr - 1'b1;
  end

  assign busy    = (tmr != '0);
  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/twe_ctrl.sv
module twe_ctrl
  import twe_pkg::*;
#(
  parameter int AW             = 9,
  parameter int PW             = 4,
  parameter bit WP_ACTIVE_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_q,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             wp_i,
  input  logic             busy,
  input  logic [7:0]       rd_data,
  output logic [AW-1:0]    ptr,
  output logic             buf_clr,
  output logic             buf_we,
  output logic [PW-1:0]    buf_idx,
  output logic [7:0]       buf_din,
  output logic             commit,
  output logic             sda_oe,
  output twe_state_e       state
);
  logic [7:0] shreg, tx;
  logic [3:0] cnt;
  logic       rw, blk, armed, mack;
  logic       wp_act;
  logic [8:0] wa;

  assign wp_act = WP_ACTIVE_HIGH ? wp_i : ~wp_i;
  assign wa     = {blk, shreg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      tx      <= '0;
      cnt     <= '0;
      rw      <= 1'b0;
      blk     <= 1'b0;
      armed   <= 1'b0;
      mack    <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      buf_clr <= 1'b0;
      buf_we  <= 1'b0;
      buf_idx <= '0;
      buf_din <= '0;
      commit  <= 1'b0;
    end else begin
      buf_clr <= 1'b0;
      buf_we  <= 1'b0;
      commit  <= 1'b0;
      if (start_det) begin
        state   <= ST_CTRL;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        armed   <= 1'b0;
        buf_clr <= 1'b1;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        sda_oe  <= 1'b0;
        commit  <= armed & ~wp_act;
        armed   <= 1'b0;
        buf_clr <= 1'b1;
      end else begin
        unique case (state)
          ST_CTRL, ST_ADDR, ST_WDAT: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_q};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (state == ST_CTRL) begin
                if (shreg[7:4] == DEV_CODE && !busy) begin
                  rw     <= shreg[0];
                  blk    <= shreg[1];
                  sda_oe <= 1'b1;
                  state  <= ST_CACK;
                end else begin
                  state  <= ST_IDLE;
                end
              end else if (state == ST_ADDR) begin
                ptr    <= wa[AW-1:0];
                sda_oe <= 1'b1;
                state  <= ST_AACK;
              end else begin
                buf_we        <= 1'b1;
                buf_idx       <= ptr[PW-1:0];
                buf_din       <= shreg;
                ptr[PW-1:0]   <= ptr[PW-1:0] + 1'b1;
                armed         <= 1'b1;
                sda_oe        <= 1'b1;
                state         <= ST_WACK;
              end
            end
          end
          ST_CACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
                ptr    <= ptr + 1'b1;
                cnt    <= 4'd1;
                state  <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_ADDR;
              end
            end
          end
          ST_AACK, ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_q;
            end else if (scl_fall) begin
              if (mack) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
                ptr    <= ptr + 1'b1;
                cnt    <= 4'd1;
                state  <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twe_eeprom.sv
module twe_eeprom
  import twe_pkg::*;
#(
  parameter int MEM_BYTES      = 512,
  parameter int PAGE_BYTES     = 16,
  parameter bit WP_ACTIVE_HIGH = 1'b1,
  parameter int WR_CYCLES      = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic wp_i
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  logic          scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic          busy, buf_clr, buf_we, commit;
  logic [AW-1:0] ptr;
  logic [PW-1:0] buf_idx;
  logic [7:0]    buf_din, rd_data;
  twe_state_e    state;

  twe_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twe_ctrl #(.AW(AW), .PW(PW), .WP_ACTIVE_HIGH(WP_ACTIVE_HIGH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .wp_i(wp_i), .busy(busy), .rd_data(rd_data), .ptr(ptr),
    .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(buf_idx), .buf_din(buf_din),
    .commit(commit), .sda_oe(sda_oe), .state(state)
  );

  twe_store #(.AW(AW), .PW(PW), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_addr(ptr), .rd_data(rd_data),
    .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(buf_idx), .buf_din(buf_din),
    .commit(commit), .page_hi(ptr[AW-1:PW]), .busy(busy)
  );
endmodule

// File: rtl/twe_eeprom_chk.sv
module twe_eeprom_chk
  import twe_pkg::*;
#(
  parameter int AW             = 9,
  parameter int PW             = 4,
  parameter bit WP_ACTIVE_HIGH = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          scl_q,
  input logic          busy,
  input logic          wp_i,
  input twe_state_e    state,
  input logic [AW-1:0] ptr
);
  // R1: pull-down is only ever raised during a clock-low phase
  a_r1_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);

  // R6: nothing is acknowledged while the internal cycle runs
  a_r6_silent_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R9: a cycle begins only if protection was off at the STOP
  a_r9_no_commit_protected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(wp_i, 2) != WP_ACTIVE_HIGH));

  // R5: page bits of the pointer hold during the data phase of a write
  a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WDAT || state == ST_WACK) &&
     ($past(state) == ST_WDAT || $past(state) == ST_WACK))
    |-> $stable(ptr[AW-1:PW]));

  // R8: slave leaves the line to the master during its acknowledge slot
  a_r8_release_for_mack: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RACK) |-> !sda_oe);
endmodule

bind twe_eeprom twe_eeprom_chk #(
  .AW(AW), .PW(PW), .WP_ACTIVE_HIGH(WP_ACTIVE_HIGH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_q(scl_q),
  .busy(busy), .wp_i(wp_i), .state(state), .ptr(ptr)
);

// File: tb/twe_eeprom_test.sv
module twe_eeprom_test;
  localparam int MEM = 512;
  localparam int PG  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  wire  line = sda_m & ~sda_oe;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] model [MEM];
  int         mptr = 0;
  logic [7:0] wbuf [32];

  always #10 clk = ~clk;

  twe_eeprom uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line),
    .sda_oe(sda_oe), .wp_i(wp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hq();
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hq();
    scl_m = 1'b1; hq();
    sda_m = 1'b0; hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq();
    scl_m = 1'b1; hq();
    sda_m = 1'b1; hq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hq();
      scl_m = 1'b1; hq(); hq();
      scl_m = 1'b0; hq();
    end
    sda_m = 1'b1; hq();
    scl_m = 1'b1; hq();
    acked = !line;
    hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b1; hq();
      d[i] = line;
      hq();
      scl_m = 1'b0; hq();
    end
    sda_m = !give_ack; hq();
    scl_m = 1'b1; hq(); hq();
    scl_m = 1'b0; hq();
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] ctl(input int addr, input bit rd);
    logic [1:0] junk = 2'($urandom);
    return {4'b1010, junk, addr[8], rd};
  endfunction

  function automatic int in_page(input int base, input int k);
    return (base & ~(PG - 1)) | ((base + k) & (PG - 1));
  endfunction

  // write n bytes from wbuf at addr; returns number of missing acks
  task automatic do_write(input int addr, input int n, output int nacks);
    bit a;
    nacks = 0;
    bus_start();
    send_byte(ctl(addr, 1'b0), a); if (!a) nacks++;
    send_byte(addr[7:0], a);       if (!a) nacks++;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], a); if (!a) nacks++;
    end
    bus_stop();
    for (int k = 0; k < n; k++)
      if (!wp) model[in_page(addr, k)] = wbuf[k];
    mptr = in_page(addr, n);
  endtask

  task automatic poll(output int tries);
    bit a;
    tries = 0;
    do begin
      tries++;
      bus_start();
      send_byte(ctl(0, 1'b0), a);
      bus_stop();
    end while (!a && tries < 60);
  endtask

  task automatic rd_check(input bit random, input int addr, input int n, input string req);
    bit a;
    logic [7:0] d;
    if (random) begin
      bus_start();
      send_byte(ctl(addr, 1'b0), a);
      send_byte(addr[7:0], a);
      mptr = addr;
    end
    bus_start();
    send_byte(ctl(addr, 1'b1), a);
    chk(a, req, a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      chk(d == model[mptr], req, d, model[mptr]);
      mptr = (mptr + 1) % MEM;
    end
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int nk, tries, addr, n;
    bit a;
    void'($urandom(32'h5eed_2077));
    for (int i = 0; i < MEM; i++) model[i] = 8'hFF;

    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R10 released in reset", sda_oe, 0);
    rst_n = 1'b1;
    hq();
    chk(sda_oe == 1'b0, "R10 released after reset", sda_oe, 0);

    // R10 + R7: first read with no address phase starts at 0
    rd_check(1'b0, 0, 2, "R10 R7 current read after reset");
    rd_check(1'b1, 9'h0A5, 1, "R10 erased contents");

    // R2: wrong device code is ignored to the next START
    bus_start();
    send_byte(8'hB0, a);
    chk(!a, "R2 wrong code nack", a, 0);
    send_byte(8'h10, a);
    chk(!a, "R2 following byte ignored", a, 0);
    send_byte(8'h3C, a);
    bus_stop();
    rd_check(1'b1, 9'h010, 1, "R2 no write from ignored bytes");

    // R1 R4 R6: byte write then polling
    wbuf[0] = 8'h5A;
    do_write(9'h123, 1, nk);
    chk(nk == 0, "R1 R4 byte write acks", nk, 0);
    poll(tries);
    chk(tries >= 2, "R6 first poll refused", tries, 2);
    chk(tries < 60, "R6 cycle ends", tries, 1);
    rd_check(1'b1, 9'h123, 1, "R4 byte stored");
    rd_check(1'b0, 0, 1, "R7 current read gives next address");

    // R3: block bit extends the address
    wbuf[0] = 8'h11;
    do_write(9'h023, 1, nk);
    poll(tries);
    rd_check(1'b1, 9'h023, 1, "R3 low block");
    rd_check(1'b1, 9'h123, 1, "R3 high block untouched");

    // R5: page write wrapping inside the page
    for (int k = 0; k < 20; k++) wbuf[k] = 8'(8'h80 + k);
    do_write(9'h045, 20, nk);
    chk(nk == 0, "R5 page write acks", nk, 0);
    poll(tries);
    rd_check(1'b1, 9'h040, PG, "R5 page wrap overwrite");
    rd_check(1'b1, 9'h050, 1, "R5 next page untouched");

    // R8: sequential read crossing the end of the array
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
    do_write(9'h1FE, 2, nk);
    poll(tries);
    wbuf[0] = 8'hC3;
    do_write(9'h000, 1, nk);
    poll(tries);
    rd_check(1'b1, 9'h1FE, 4, "R8 sequential wraps to 0");
    hq();
    chk(sda_oe == 1'b0, "R8 released after master nack", sda_oe, 0);

    // R9: protected write acked but not committed, no cycle
    wp = 1'b1;
    hq();
    wbuf[0] = 8'h77;
    do_write(9'h060, 1, nk);
    chk(nk == 0, "R9 protected bytes still acked", nk, 0);
    poll(tries);
    chk(tries == 1, "R9 no internal cycle", tries, 1);
    rd_check(1'b1, 9'h060, 1, "R9 array unchanged");
    wp = 1'b0;
    hq();

    // random mix, R4 R5 R7
    for (int it = 0; it < 10; it++) begin
      addr = int'($urandom_range(MEM - 1, 0));
      n    = int'($urandom_range(12, 1));
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      do_write(addr, n, nk);
      chk(nk == 0, "R4 random write acks", nk, 0);
      poll(tries);
      rd_check(1'b1, addr & ~(PG - 1), PG, "R5 random page readback");
      rd_check(1'b0, 0, 1, "R7 random current read");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule